// File: doc/BRIEF.md
# I2C Target with 16-bit Register Bank Access

This block is a bus target for a two-wire serial bus. It sits in front of a bank of 16-bit registers. Both bus lines are oversampled with the system clock. The block finds start, repeated-start and stop conditions and accepts a 7-bit device address in which only the upper five bits are compared. After the address it takes a one-byte register pointer. It then moves whole registers as two bytes, the high byte first. The pointer advances by one after each register.

The register storage sits outside the block and is reached through a plain parallel port. A registered write strobe carries the address and the 16-bit word once both bytes of a pair have arrived. A read address output selects the word that the outside logic returns on the read data input.

The pointer never wraps. Once the top register has been written, later pairs in the same transaction are acknowledged but thrown away. A read that runs past the top register keeps returning the top register.

Top module: `i2c_reg16_target`

## Requirements
- R1: While reset is held and in the first cycle after it, the target does not pull SDA low (`sda_oe` = 0) and issues no register write (`rf_we` = 0).
- R2: An address byte whose upper five bits are 01011 is acknowledged for every value of address bits 2:1, and for either value of bit 0 (0 = write, 1 = read). The acknowledge pulls SDA low during the ninth SCL clock. Every byte received in a write transaction is acknowledged in the same way.
- R3: After an address byte that does not match, the target neither acknowledges nor drives SDA. It issues no register write until the next START.
- R4: In a write, the first byte after the address loads the pointer. Each following pair of bytes, high byte then low byte, produces exactly one single-cycle `rf_we` pulse. That pulse carries `rf_waddr` equal to the pointer and `rf_wdata` equal to {high, low}.
- R5: After each committed register the pointer increases by one, so consecutive pairs land in consecutive registers.
- R6: In a read, the target returns the high byte and then the low byte of the register at the pointer, and then moves to the next register. The pointer can be set by a write that ends with a repeated START or with a STOP.
- R7: Once the register at address NUM_REGS-1 has been written, later pairs in the same transaction are still acknowledged, but they produce no write.
- R8: A read that continues beyond register NUM_REGS-1 returns that register's contents again and again.
- R9: A lone high byte that is not followed by its low byte before a STOP or repeated START is discarded. The register it addressed keeps its value.
- R10: A pointer byte larger than NUM_REGS-1 is treated as NUM_REGS-1.
- R11: After the controller answers a read byte with NACK, the target releases SDA and sends no further bits until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| rf_raddr | output | PTR_W | Register read address |
| rf_rdata | input | 16 | Register contents at `rf_raddr` |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_waddr | output | PTR_W | Register write address |
| rf_wdata | output | 16 | Register write data, high byte in bits 15:8 |

## Verification
The bench builds the block with NUM_REGS = 8. With that value a few pairs written from pointer 6 reach the top register and then run past it, which makes the silent drop and the repeated top-register read cheap to exercise. Pointer bytes such as 0x50 and 0xFF then exercise the clamp. SCL runs at forty system cycles per bit. The synchronizer delay is therefore small against each bus phase, yet it is still counted in where the bench samples SDA.

// File: rtl/i2c_r16_pkg.sv
package i2c_r16_pkg;

    // Upper five bits of the accepted device address; the two below are free.
    localparam logic [4:0] DEV_PREFIX = 5'b01011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } xact_state_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_FRAME,
        EV_PTR,
        EV_WBYTE,
        EV_RBYTE
    } byte_ev_e;

    typedef struct packed {
        logic scl_hi;
        logic sda_hi;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        byte_ev_e   kind;
        logic [7:0] data;
    } byte_evt_t;

    function automatic logic addr_hit(logic [7:0] b);
        return b[7:3] == DEV_PREFIX;
    endfunction

    function automatic int unsigned clamp_index(logic [7:0] raw, int unsigned top);
        int unsigned r;
        r = raw;
        return (r > top) ? top : r;
    endfunction

endpackage

// File: rtl/i2c_r16_line.sv
module i2c_r16_line
    import i2c_r16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;
    logic                   scl_s;
    logic                   sda_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.scl_hi   = scl_s;
        evt.sda_hi   = sda_s;
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_r16_xact.sv
module i2c_r16_xact
    import i2c_r16_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   bus,
    input  logic [7:0] tx_byte,
    output byte_evt_t  bev,
    output logic       sda_oe
);
    xact_state_e state;
    logic [3:0]  bitcnt;
    logic [7:0]  rx_sh;
    logic [7:0]  tx_sh;
    logic        rd_mode;
    logic        ptr_phase;
    logic        m_nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rd_mode   <= 1'b0;
            ptr_phase <= 1'b0;
            m_nack    <= 1'b0;
            sda_oe    <= 1'b0;
            bev.kind  <= EV_NONE;
            bev.data  <= '0;
        end else begin
            bev.kind <= EV_NONE;
            if (bus.start) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                sda_oe   <= 1'b0;
                bev.kind <= EV_FRAME;
            end else if (bus.stop) begin
                state    <= ST_IDLE;
                sda_oe   <= 1'b0;
                bev.kind <= EV_FRAME;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (bus.scl_rise && bitcnt < 4'd8) begin
                            rx_sh  <= {rx_sh[6:0], bus.sda_hi};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (bus.scl_fall && bitcnt == 4'd8) begin
                            if (state == ST_ADDR) begin
                                if (addr_hit(rx_sh)) begin
                                    sda_oe    <= 1'b1;
                                    state     <= ST_ACK;
                                    rd_mode   <= rx_sh[0];
                                    ptr_phase <= 1'b1;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else begin
                                bev.data  <= rx_sh;
                                bev.kind  <= ptr_phase ? EV_PTR : EV_WBYTE;
                                ptr_phase <= 1'b0;
                                sda_oe    <= 1'b1;
                                state     <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (bus.scl_fall) begin
                            bitcnt <= '0;
                            if (rd_mode) begin
                                state    <= ST_RDATA;
                                tx_sh    <= tx_byte;
                                sda_oe   <= ~tx_byte[7];
                                bev.kind <= EV_RBYTE;
                            end else begin
                                state  <= ST_WDATA;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (bus.scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                state  <= ST_RACK;
                                sda_oe <= 1'b0;
                            end else begin
                                bitcnt <= bitcnt + 4'd1;
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (bus.scl_rise) begin
                            m_nack <= bus.sda_hi;
                        end else if (bus.scl_fall) begin
                            bitcnt <= '0;
                            if (m_nack) begin
                                state <= ST_IGNORE;
                            end else begin
                                state    <= ST_RDATA;
                                tx_sh    <= tx_byte;
                                sda_oe   <= ~tx_byte[7];
                                bev.kind <= EV_RBYTE;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // Silent states never pull the line and never pass bytes onward.
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE || state == ST_IDLE) |-> (!sda_oe && bev.kind != EV_WBYTE && bev.kind != EV_PTR)); // R3

    // The target only changes its SDA drive while SCL is low.
    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (bus.scl_hi && $past(bus.scl_hi)) |-> $stable(sda_oe)); // R2

endmodule

// File: rtl/i2c_r16_ptr.sv
module i2c_r16_ptr
    import i2c_r16_pkg::*;
#(
    parameter  int NUM_REGS = 64,
    localparam int PTR_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  byte_evt_t        bev,
    input  logic [15:0]      rf_rdata,
    output logic [PTR_W-1:0] rf_raddr,
    output logic             rf_we,
    output logic [PTR_W-1:0] rf_waddr,
    output logic [15:0]      rf_wdata,
    output logic [7:0]       tx_byte
);
    localparam int unsigned      TOP_I = NUM_REGS - 1;
    localparam logic [PTR_W-1:0] TOP   = PTR_W'(TOP_I);

    logic [PTR_W-1:0] ptr;
    logic             sat;
    logic             half;
    logic [7:0]       hold_hi;
    logic [7:0]       tx_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            sat      <= 1'b0;
            half     <= 1'b0;
            hold_hi  <= '0;
            tx_lo    <= '0;
            rf_we    <= 1'b0;
            rf_waddr <= '0;
            rf_wdata <= '0;
        end else begin
            rf_we <= 1'b0;
            unique case (bev.kind)
                EV_FRAME: half <= 1'b0;
                EV_PTR: begin
                    ptr  <= PTR_W'(clamp_index(bev.data, TOP_I));
                    sat  <= 1'b0;
                    half <= 1'b0;
                end
                EV_WBYTE: begin
                    if (!half) begin
                        hold_hi <= bev.data;
                        half    <= 1'b1;
                    end else begin
                        half <= 1'b0;
                        if (!sat) begin
                            rf_we    <= 1'b1;
                            rf_waddr <= ptr;
                            rf_wdata <= {hold_hi, bev.data};
                            if (ptr == TOP) sat <= 1'b1;
                            else            ptr <= ptr + 1'b1;
                        end
                    end
                end
                EV_RBYTE: begin
                    if (!half) begin
                        tx_lo <= rf_rdata[7:0];
                        half  <= 1'b1;
                        if (ptr != TOP) ptr <= ptr + 1'b1;
                    end else begin
                        half <= 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign rf_raddr = ptr;
    assign tx_byte  = half ? tx_lo : rf_rdata[15:8];

    AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (bev.kind == EV_WBYTE && half && !sat && ptr != TOP) |=> (ptr == $past(ptr) + 1'b1)); // R5

    AST_NO_WRITE_PAST_TOP: assert property (@(posedge clk) disable iff (rst)
        (sat && bev.kind != EV_PTR) |=> !rf_we); // R7

    AST_PTR_HOLDS_TOP: assert property (@(posedge clk) disable iff (rst)
        (ptr == TOP && bev.kind != EV_PTR) |=> (ptr == TOP)); // R8

endmodule

// File: rtl/i2c_reg16_target.sv
module i2c_reg16_target
    import i2c_r16_pkg::*;
#(
    parameter  int NUM_REGS    = 64,
    parameter  int SYNC_STAGES = 2,
    localparam int PTR_W       = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [PTR_W-1:0] rf_raddr,
    input  logic [15:0]      rf_rdata,
    output logic             rf_we,
    output logic [PTR_W-1:0] rf_waddr,
    output logic [15:0]      rf_wdata
);
    bus_evt_t  bus;
    byte_evt_t bev;
    logic [7:0] tx_byte;

    i2c_r16_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (bus)
    );

    i2c_r16_xact u_xact (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .tx_byte (tx_byte),
        .bev     (bev),
        .sda_oe  (sda_oe)
    );

    i2c_r16_ptr #(.NUM_REGS(NUM_REGS)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .bev      (bev),
        .rf_rdata (rf_rdata),
        .rf_raddr (rf_raddr),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata),
        .tx_byte  (tx_byte)
    );

    // Reset leaves the bus released and the register port quiet.
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !rf_we)); // R1

endmodule

// File: tb/sim_i2c_reg16_target.sv
module sim_i2c_reg16_target;
    localparam int NR    = 8;
    localparam int PW    = $clog2(NR);
    localparam int Q     = 10;
    localparam int TOP   = NR - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [PW-1:0] rf_raddr;
    logic [PW-1:0] rf_waddr;
    logic [15:0]   rf_rdata;
    logic [15:0]   rf_wdata;
    logic          rf_we;
    logic          sda_bus;

    int nchk  = 0;
    int nfail = 0;

    typedef struct { int a; logic [15:0] d; } wexp_t;
    wexp_t wr_q[$];
    logic [15:0] rfile [NR];
    logic [15:0] mdl   [NR];

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_reg16_target #(.NUM_REGS(NR)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    function automatic logic [15:0] init_val(int i);
        return 16'h5A00 ^ 16'(i * 16'h0123);
    endfunction

    // External register file.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NR; i++) rfile[i] <= init_val(i);
        end else if (rf_we) begin
            rfile[rf_waddr] <= rf_wdata;
        end
    end
    assign rf_rdata = rfile[rf_raddr];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Monitor: every write strobe is popped and compared.
    always @(negedge clk) begin
        if (!rst && rf_we) begin
            if (wr_q.size() == 0) begin
                chk("R7 unexpected write addr", 32'(rf_waddr), 32'hFFFF_FFFF);
            end else begin
                wexp_t e;
                e = wr_q.pop_front();
                chk("R4 write addr", 32'(rf_waddr), 32'(e.a));
                chk("R4 write data", 32'(rf_wdata), 32'(e.d));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        b = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic nack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(nack);
    endtask

    // Driver: pushes predicted writes, updates the model.
    task automatic do_write(input logic [6:0] dev, input logic [7:0] pb, input int npairs,
                            input logic [15:0] base, input string req);
        logic ack;
        int   p;
        logic sat;
        p   = (int'(pb) > TOP) ? TOP : int'(pb);
        sat = 1'b0;
        bus_start();
        put_byte({dev, 1'b0}, ack); chk({"R2 addr ack ", req}, 32'(ack), 1);
        put_byte(pb, ack);          chk({"R2 ptr ack ", req}, 32'(ack), 1);
        for (int k = 0; k < npairs; k++) begin
            logic [15:0] d;
            d = base + 16'(k * 16'h0203);
            if (!sat) begin
                wr_q.push_back('{p, d});
                mdl[p] = d;
                if (p == TOP) sat = 1'b1; else p++;
            end
            put_byte(d[15:8], ack); chk({"R2 hi ack ", req}, 32'(ack), 1);
            put_byte(d[7:0], ack);  chk({"R2 lo ack ", req}, 32'(ack), 1);
        end
        bus_stop();
        tick(4);
    endtask

    task automatic do_read(input logic [6:0] dev, input logic [7:0] pb, input int nregs,
                           input logic use_rs, input string req);
        logic ack;
        logic b;
        int   p;
        p = (int'(pb) > TOP) ? TOP : int'(pb);
        bus_start();
        put_byte({dev, 1'b0}, ack); chk({"R2 addr ack ", req}, 32'(ack), 1);
        put_byte(pb, ack);          chk({"R2 ptr ack ", req}, 32'(ack), 1);
        if (!use_rs) bus_stop();
        bus_start();
        put_byte({dev, 1'b1}, ack); chk({"R2 rd addr ack ", req}, 32'(ack), 1);
        for (int k = 0; k < nregs; k++) begin
            logic [7:0] hi;
            logic [7:0] lo;
            get_byte(hi, 1'b0);
            get_byte(lo, (k == nregs - 1));
            chk({"R6 read word ", req}, 32'({hi, lo}), 32'(mdl[p]));
            if (p != TOP) p++;
        end
        get_bit(b);
        chk("R11 released after NACK", 32'(b), 1);
        bus_stop();
        tick(4);
    endtask

    initial begin : main
        logic ack;
        for (int i = 0; i < NR; i++) mdl[i] = init_val(i);
        tick(2);
        chk("R1 sda_oe in reset", 32'(sda_oe), 0);
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 sda_oe after reset", 32'(sda_oe), 0);
        chk("R1 rf_we after reset", 32'(rf_we), 0);
        tick(20);

        // R4 R5 R6: two registers, read back after repeated START
        do_write(7'h2C, 8'h02, 2, 16'hA1B2, "R4");
        do_read (7'h2D, 8'h02, 2, 1'b1, "R5");

        // R2 other don't-care bits, R6 read after STOP
        do_write(7'h2F, 8'h05, 1, 16'h3C4D, "R2");
        do_read (7'h2E, 8'h05, 1, 1'b0, "R6");

        // R3: foreign address is ignored
        bus_start();
        put_byte({7'h3C, 1'b0}, ack); chk("R3 no addr ack", 32'(ack), 0);
        put_byte(8'h01, ack);         chk("R3 no byte ack", 32'(ack), 0);
        put_byte(8'hDE, ack);         chk("R3 no data ack", 32'(ack), 0);
        bus_stop();
        tick(4);
        do_read(7'h2C, 8'h01, 1, 1'b1, "R3");

        // R7: three pairs from pointer 6, third dropped
        do_write(7'h2C, 8'h06, 3, 16'h7711, "R7");
        do_read (7'h2C, 8'h07, 1, 1'b1, "R7");

        // R8: read past the top
        do_read (7'h2C, 8'h06, 4, 1'b1, "R8");

        // R9: lone high byte before STOP
        bus_start();
        put_byte({7'h2C, 1'b0}, ack); chk("R9 addr ack", 32'(ack), 1);
        put_byte(8'h01, ack);         chk("R9 ptr ack", 32'(ack), 1);
        put_byte(8'hEE, ack);         chk("R9 byte ack", 32'(ack), 1);
        bus_stop();
        tick(4);
        do_read(7'h2C, 8'h01, 1, 1'b1, "R9");

        // R9: lone high byte before repeated START, then read register 4
        begin
            logic [7:0] hi;
            logic [7:0] lo;
            bus_start();
            put_byte({7'h2C, 1'b0}, ack);
            put_byte(8'h04, ack);
            put_byte(8'h99, ack); chk("R9 rs byte ack", 32'(ack), 1);
            bus_start();
            put_byte({7'h2C, 1'b1}, ack); chk("R9 rs rd ack", 32'(ack), 1);
            get_byte(hi, 1'b0);
            get_byte(lo, 1'b1);
            chk("R9 reg4 unchanged", 32'({hi, lo}), 32'(mdl[4]));
            bus_stop();
            tick(4);
        end

        // R10: oversized pointer bytes clamp to the top register
        do_write(7'h2C, 8'h50, 1, 16'hBEEF, "R10");
        do_read (7'h2C, 8'hFF, 1, 1'b1, "R10");

        tick(10);
        chk("R4 all writes seen", 32'(wr_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule